// File: doc/BRIEF.md
# Platform Reset Request Register

This block is a single byte-wide register on the I/O port space that host software uses to ask the platform for a reset. It answers only at one fixed port number, stores whatever byte software writes there, and returns that byte on a read. Two bits of the stored byte carry meaning. One arms the reset: when a write moves it from clear to set, the block emits a one-cycle reset request. The other tells the downstream reset sequencer whether a hard or a soft reset is wanted. The sequencer may treat both kinds alike.

Accesses arrive as single-cycle requests carrying an address, a direction, an access-size code and write data. Every request that hits the port is answered one cycle later with an acknowledge. Any access size other than one byte is refused. The refusal is an acknowledge together with an error flag, and it leaves the register and the reset output untouched. Requests to any other port get no answer, so another device can respond to them.

Top module: `sys_reset_ctl`

## Requirements
- R1: After synchronous reset, the stored byte is 0x00, and `io_ack`, `io_err`, `io_rdata` and `rst_req` are all low.
- R2: Only a request whose full address equals 0x0CF9 is acknowledged. A request to any other address gets no `io_ack`, does not change the stored byte and does not raise `rst_req`.
- R3: A request with `io_size` = 0 (one byte) and `io_we` = 1 stores `io_wdata[7:0]`. A one-byte read returns the most recently stored byte on `io_rdata[7:0]`, with bits 31:8 at zero.
- R4: A request to the port with `io_size` other than 0 (1 = two bytes, 2 = four bytes, 3 = reserved) is acknowledged with `io_err` high. It leaves the stored byte unchanged, raises no `rst_req`, and returns zero on `io_rdata`.
- R5: When a legal write moves stored bit 2 from 0 to 1, `rst_req` is high for exactly the one cycle after the write is accepted, which is the same cycle as its `io_ack`.
- R6: A legal write with bit 2 set while stored bit 2 is already 1 produces no further `rst_req` pulse.
- R7: `rst_hard` equals stored bit 1: 1 requests a hard reset and 0 a soft reset. During an `rst_req` pulse it shows the bit 1 of the triggering write.
- R8: After bit 2 has been written back to 0, a later write that sets it again produces a new pulse, including when the writes are on back-to-back cycles.
- R9: Each request to the port gives `io_ack` high for exactly the following cycle. `io_err` is never high without `io_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Access request, valid for one cycle |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | Access size code: 0 byte, 1 two bytes, 2 four bytes, 3 reserved |
| io_wdata | input | 32 | Write data; only bits 7:0 are stored |
| io_ack | output | 1 | Response strobe, one cycle after a request that hits the port |
| io_err | output | 1 | Access refused because of its size; only ever high with io_ack |
| io_rdata | output | 32 | Read data, valid with io_ack |
| rst_req | output | 1 | One-cycle platform reset request |
| rst_hard | output | 1 | Reset type: 1 hard, 0 soft |

## Verification
The assertions assume that inputs are idle while reset is held. They also assume that reset is held for at least two clocks, so that the first comparison of stored state after reset sees a defined previous value. The bench holds reset for five cycles with the request low. It drives every request half a cycle before the sampling edge, so the address, size and data are stable when they are captured. Back-to-back requests are allowed by the assertions, and the bench uses them on purpose to show that a clear and a re-arm on consecutive cycles each take effect.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    localparam int unsigned IO_ADDR_W = 16;
    localparam int unsigned IO_DATA_W = 32;
    localparam int unsigned RCR_W     = 8;
    localparam int unsigned SIZE_W    = 2;
    localparam int unsigned ARM_BIT   = 2;
    localparam int unsigned KIND_BIT  = 1;
    localparam logic [IO_ADDR_W-1:0] RCR_PORT = 16'h0CF9;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } io_size_e;

    typedef struct packed {
        logic hit;
        logic legal;
        logic wr;
        logic rd;
    } io_dec_t;

    function automatic logic edge_up(input logic was, input logic now);
        return !was && now;
    endfunction

endpackage

// File: rtl/rcr_decode.sv
module rcr_decode
    import rcr_pkg::*;
#(
    parameter int unsigned ADDR_W = IO_ADDR_W,
    parameter logic [ADDR_W-1:0] PORT = ADDR_W'(RCR_PORT)
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output io_dec_t           dec
);
    io_size_e sz;
    assign sz = io_size_e'(size);

    always_comb begin
        dec.hit   = req && (addr == PORT);
        dec.legal = dec.hit && (sz == SZ_BYTE);
        dec.wr    = dec.legal && we;
        dec.rd    = dec.legal && !we;
    end
endmodule

// File: rtl/rcr_store.sv
module rcr_store
    import rcr_pkg::*;
#(
    parameter int unsigned REG_W  = RCR_W,
    parameter int unsigned ARM_B  = ARM_BIT,
    parameter int unsigned KIND_B = KIND_BIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q,
    output logic             fire,
    output logic             hard
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            fire <= 1'b0;
        end else begin
            fire <= wr_en && edge_up(q[ARM_B], wdata[ARM_B]);
            if (wr_en) begin
                q <= wdata;
            end
        end
    end

    assign hard = q[KIND_B];

    // R6: a pulse only ever follows a stored arm bit that was clear
    a_r6_no_rearm_pulse: assert property (@(posedge clk) disable iff (rst)
        fire |-> !$past(q[ARM_B]));

    // R3/R4: the byte only moves on a legal write
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(q));

    // R5: a pulse lasts one cycle
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
endmodule

// File: rtl/rcr_resp.sv
module rcr_resp
    import rcr_pkg::*;
#(
    parameter int unsigned DATA_W = IO_DATA_W,
    parameter int unsigned REG_W  = RCR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  io_dec_t           dec,
    input  logic [REG_W-1:0]  q,
    output logic              ack,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned PAD_W = DATA_W - REG_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= dec.hit;
            err   <= dec.hit && !dec.legal;
            rdata <= dec.rd ? {{PAD_W{1'b0}}, q} : '0;
        end
    end

    // R9: error flag rides only on an acknowledge
    a_r9_err_with_ack: assert property (@(posedge clk) disable iff (rst)
        err |-> ack);

    // R9: acknowledge answers a hit one cycle earlier
    a_r9_ack_follows_hit: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(dec.hit));

    // R4: refused access returns no data
    a_r4_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        err |-> (rdata == '0));
endmodule

// File: rtl/sys_reset_ctl.sv
module sys_reset_ctl
    import rcr_pkg::*;
#(
    parameter int unsigned ADDR_W = IO_ADDR_W,
    parameter int unsigned DATA_W = IO_DATA_W,
    parameter int unsigned REG_W  = RCR_W,
    parameter logic [ADDR_W-1:0] PORT = ADDR_W'(RCR_PORT),
    parameter int unsigned ARM_B  = ARM_BIT,
    parameter int unsigned KIND_B = KIND_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_req,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [SIZE_W-1:0] io_size,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              io_ack,
    output logic              io_err,
    output logic [DATA_W-1:0] io_rdata,
    output logic              rst_req,
    output logic              rst_hard
);
    io_dec_t          dec;
    logic [REG_W-1:0] q;
    logic             unused_hi;

    assign unused_hi = ^io_wdata[DATA_W-1:REG_W];

    rcr_decode #(.ADDR_W(ADDR_W), .PORT(PORT)) u_dec (
        .req  (io_req),
        .we   (io_we),
        .addr (io_addr),
        .size (io_size),
        .dec  (dec)
    );

    rcr_store #(.REG_W(REG_W), .ARM_B(ARM_B), .KIND_B(KIND_B)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (dec.wr),
        .wdata (io_wdata[REG_W-1:0]),
        .q     (q),
        .fire  (rst_req),
        .hard  (rst_hard)
    );

    rcr_resp #(.DATA_W(DATA_W), .REG_W(REG_W)) u_resp (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .q     (q),
        .ack   (io_ack),
        .err   (io_err),
        .rdata (io_rdata)
    );

    // R5: every pulse comes from a legal write one cycle earlier
    a_r5_pulse_from_write: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(dec.wr));

    // R4: a refused access never requests a reset
    a_r4_err_no_pulse: assert property (@(posedge clk) disable iff (rst)
        io_err |-> !rst_req);

    // R2: off-port requests are never answered
    a_r2_off_port_silent: assert property (@(posedge clk) disable iff (rst)
        ($past(io_req) && ($past(io_addr) != PORT)) |-> !io_ack);
endmodule

// File: tb/tb_sys_reset_ctl.sv
module tb_sys_reset_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_req = 1'b0;
    logic        io_we = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic        io_ack, io_err, rst_req, rst_hard;
    logic [31:0] io_rdata;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    bit finished = 1'b0;

    // reference model state
    logic [7:0]  m_reg = '0;
    logic        e_ack = 1'b0, e_err = 1'b0, e_req = 1'b0, e_hard = 1'b0;
    logic [31:0] e_rdata = '0;

    always #4 clk = ~clk;

    sys_reset_ctl dut (
        .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
        .io_ack(io_ack), .io_err(io_err), .io_rdata(io_rdata),
        .rst_req(rst_req), .rst_hard(rst_hard)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        logic hit, ok;
        if (rst) begin
            m_reg = '0; e_ack = 0; e_err = 0; e_req = 0; e_rdata = '0;
        end else begin
            hit = io_req && (io_addr == 16'h0CF9);
            ok  = hit && (io_size == 2'd0);
            e_ack = hit;
            e_err = hit && !ok;
            e_rdata = (ok && !io_we) ? {24'h0, m_reg} : 32'h0;
            e_req = 0;
            if (ok && io_we) begin
                e_req = !m_reg[2] && io_wdata[2];
                m_reg = io_wdata[7:0];
            end
        end
        e_hard = m_reg[1];
    end

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R9 io_ack", 32'(io_ack), 32'(e_ack));
            chk("R4 io_err", 32'(io_err), 32'(e_err));
            chk("R3 io_rdata", io_rdata, e_rdata);
            chk("R5 rst_req", 32'(rst_req), 32'(e_req));
            chk("R7 rst_hard", 32'(rst_hard), 32'(e_hard));
            if (rst_req) pulses++;
        end
    end

    task automatic issue(input logic we, input logic [15:0] a, input logic [1:0] sz,
                         input logic [31:0] d);
        @(negedge clk);
        io_req = 1'b1; io_we = we; io_addr = a; io_size = sz; io_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        io_req = 1'b0; io_we = 1'b0; io_wdata = '0;
    endtask

    task automatic op(input logic we, input logic [15:0] a, input logic [1:0] sz,
                      input logic [31:0] d);
        issue(we, a, sz, d);
        idle();
    endtask

    // read at the port, return data seen with the acknowledge
    task automatic rd(output logic [31:0] v);
        issue(1'b0, 16'h0CF9, 2'd0, 32'h0);
        idle();
        v = io_rdata;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        chk("R1 ack in reset", 32'(io_ack), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rst_req after reset", 32'(rst_req), 0);
        chk("R1 rst_hard after reset", 32'(rst_hard), 0);
        rd(v); chk("R1 reset byte", v, 32'h0);

        op(1, 16'h0CF9, 0, 32'hFFFF_FF02); // R3 upper bits dropped
        rd(v); chk("R3 readback", v, 32'h02);
        chk("R7 hard level", 32'(rst_hard), 1);
        chk("R5 no pulse without arm", 32'(pulses), 0);

        op(1, 16'h0CF9, 0, 32'h06);        // R5 arm, hard
        @(negedge clk);
        chk("R5 one pulse", 32'(pulses), 1);
        op(1, 16'h0CF9, 0, 32'h06);        // R6 repeat
        op(1, 16'h0CF9, 0, 32'h04);
        @(negedge clk);
        chk("R6 no repeat pulse", 32'(pulses), 1);
        chk("R7 soft level", 32'(rst_hard), 0);

        op(1, 16'h0CF9, 0, 32'h00);        // R8 clear then re-arm
        op(1, 16'h0CF9, 0, 32'h04);
        @(negedge clk);
        chk("R8 re-arm pulse", 32'(pulses), 2);

        op(1, 16'h0CF9, 1, 32'h00);        // R4 word write refused
        rd(v); chk("R4 byte kept", v, 32'h04);
        op(0, 16'h0CF9, 2, 32'h00);        // R4 dword read refused
        op(1, 16'h0CF9, 0, 32'h00);
        op(1, 16'h0CF9, 3, 32'h04);        // R4 reserved size write
        op(1, 16'h0CF9, 1, 32'h06);
        @(negedge clk);
        chk("R4 no pulse from refused", 32'(pulses), 2);
        rd(v); chk("R4 byte unchanged", v, 32'h00);

        op(1, 16'h0CF8, 0, 32'h04);        // R2 neighbours
        op(1, 16'h1CF9, 0, 32'h06);
        op(0, 16'h0CFA, 0, 32'h00);
        @(negedge clk);
        chk("R2 no pulse off port", 32'(pulses), 2);
        rd(v); chk("R2 byte unchanged", v, 32'h00);

        issue(1, 16'h0CF9, 0, 32'h04);     // R8 back-to-back
        issue(1, 16'h0CF9, 0, 32'h00);
        issue(1, 16'h0CF9, 0, 32'h06);
        idle();
        @(negedge clk);
        chk("R8 back-to-back pulses", 32'(pulses), 4);
        rd(v); chk("R3 final readback", v, 32'h06);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule